// File: doc/BRIEF.md
# Instruction Format Decoder and Address Generator

This block accepts a fetched instruction of one or two halfwords. It classifies the instruction by the two most significant opcode bits into one of three forms:

- register-to-register,
- storage with an index,
- storage without an index.

It also reports the length in halfwords and splits out the register, base and displacement fields. For the two storage forms it drives two read-port selects toward an external general register file. The file answers in the same cycle. The block then forms a 24-bit effective address from base contents, index contents (indexed form only) and displacement.

All results are registered and appear one cycle after the input strobe, together with a valid strobe. Opcodes whose top bits are 11 belong to a longer form that this block does not handle; they are flagged as unsupported. Execution, instruction fetch and the storage access itself happen elsewhere.

Top module: `insn_fmt_agen`

## Requirements
- R1: After reset, `out_valid`, `out_unsup` and every field and address output read zero.
- R2: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high, and low otherwise; outputs update only on accepted inputs.
- R3: Opcode bits [31:30] = 00 yields `out_fmt` = 0 (register-to-register) and `out_len` = 1.
- R4: Opcode bits [31:30] = 01 yields `out_fmt` = 1 (indexed storage), and 10 yields `out_fmt` = 2 (non-indexed storage); both report `out_len` = 2.
- R5: Opcode bits [31:30] = 11 yields `out_unsup` = 1, `out_fmt` = 3, `out_len` = 3 and `out_ea` = 0; `out_unsup` is 0 for every other form.
- R6: Fields are taken as opcode = [31:24], first register = [23:20], second field = [19:16], base = [15:12], displacement = [11:0]. In register-to-register form the reported base and displacement are zero.
- R7: In indexed form, `out_ea` = low 24 bits of base contents + low 24 bits of index contents + zero-extended displacement, modulo 2^24.
- R8: In non-indexed form, `out_ea` = low 24 bits of base contents + displacement. The second field is reported as a third register and adds nothing to the address.
- R9: A base field of 0 contributes zero to the address, whatever register 0 holds.
- R10: An index field of 0 contributes zero to the address, whatever register 0 holds.
- R11: In register-to-register form, `out_ea` is zero.
- R12: `rd_base_sel` follows in_insn[15:12] and `rd_idx_sel` follows in_insn[19:16] combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_insn | input | 32 | First halfword in [31:16], second halfword in [15:0] |
| rd_base_sel | output | 4 | Register file read select for base |
| rd_base_data | input | 32 | Register file data for base |
| rd_idx_sel | output | 4 | Register file read select for index |
| rd_idx_data | input | 32 | Register file data for index |
| out_valid | output | 1 | Registered result strobe |
| out_opcode | output | 8 | Opcode |
| out_fmt | output | 2 | Form code 0..3 |
| out_len | output | 2 | Length in halfwords |
| out_unsup | output | 1 | Unsupported longer form |
| out_r1 | output | 4 | First operand / destination register |
| out_r2 | output | 4 | Second operand, index, or third register |
| out_base | output | 4 | Base register field |
| out_disp | output | 12 | Displacement |
| out_ea | output | 24 | Effective address |

## Verification
Register 0 is loaded with a nonzero value and named as base and as index. A design that reads the register file for field 0 instead of substituting zero produces an address that is off by that value.

Every register carries nonzero upper bits. An adder that lets bits above 23 leak into the sum, or that fails to wrap at 2^24, shows a wrong address on a sum crafted to overflow.

Non-indexed instructions carry a nonzero second field. An index term added for the wrong form therefore shows up.

The unsupported top bits and an idle input check for a missing flag, a leftover address and a spurious strobe.

// File: rtl/insn_fmt_agen.sv
module insn_fmt_agen #(
  parameter int EA_W   = 24,
  parameter int REG_W  = 32,
  parameter int DISP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       in_insn,
  output logic [3:0]        rd_base_sel,
  input  logic [REG_W-1:0]  rd_base_data,
  output logic [3:0]        rd_idx_sel,
  input  logic [REG_W-1:0]  rd_idx_data,
  output logic              out_valid,
  output logic [7:0]        out_opcode,
  output logic [1:0]        out_fmt,
  output logic [1:0]        out_len,
  output logic              out_unsup,
  output logic [3:0]        out_r1,
  output logic [3:0]        out_r2,
  output logic [3:0]        out_base,
  output logic [DISP_W-1:0] out_disp,
  output logic [EA_W-1:0]   out_ea
);
  localparam logic [1:0] F_RR = 2'd0, F_RX = 2'd1, F_RS = 2'd2, F_LONG = 2'd3;

  logic [1:0]        fmt;
  logic [3:0]        base_f, idx_f;
  logic [EA_W-1:0]   base_term, idx_term, ea;
  logic [DISP_W-1:0] disp;
  logic [1:0]        len;
  logic              storage;

  assign fmt     = in_insn[31:30];
  assign base_f  = in_insn[15:12];
  assign idx_f   = in_insn[19:16];
  assign disp    = in_insn[DISP_W-1:0];
  assign storage = (fmt == F_RX) || (fmt == F_RS);

  assign rd_base_sel = base_f;
  assign rd_idx_sel  = idx_f;

  assign base_term = (storage && base_f != 4'd0) ? rd_base_data[EA_W-1:0] : '0;
  assign idx_term  = (fmt == F_RX && idx_f != 4'd0) ? rd_idx_data[EA_W-1:0] : '0;
  assign ea        = storage ? base_term + idx_term + EA_W'(disp) : '0;

  always_comb begin
    case (fmt)
      F_RR:    len = 2'd1;
      F_LONG:  len = 2'd3;
      default: len = 2'd2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_opcode <= '0;
      out_fmt    <= '0;
      out_len    <= '0;
      out_unsup  <= 1'b0;
      out_r1     <= '0;
      out_r2     <= '0;
      out_base   <= '0;
      out_disp   <= '0;
      out_ea     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_opcode <= in_insn[31:24];
        out_fmt    <= fmt;
        out_len    <= len;
        out_unsup  <= (fmt == F_LONG);
        out_r1     <= in_insn[23:20];
        out_r2     <= idx_f;
        out_base   <= storage ? base_f : 4'd0;
        out_disp   <= storage ? disp : '0;
        out_ea     <= ea;
      end
    end
  end
endmodule

// File: rtl/insn_fmt_agen_chk.sv
module insn_fmt_agen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_insn,
  input logic        out_valid,
  input logic [1:0]  out_fmt,
  input logic [1:0]  out_len,
  input logic        out_unsup,
  input logic [3:0]  out_r2,
  input logic [23:0] out_ea
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_UNSUP_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_insn[31:30] == 2'b11 |=> out_unsup && out_fmt == 2'd3 && out_len == 2'd3 && out_ea == 24'd0); // R5
  AST_RR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_insn[31:30] == 2'b00 |=> !out_unsup && out_len == 2'd1 && out_ea == 24'd0); // R11
  AST_RS_BASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_insn[31:30] == 2'b10 && in_insn[15:12] == 4'd0
    |=> out_ea == {12'd0, $past(in_insn[11:0])} && out_r2 == $past(in_insn[19:16])); // R9
endmodule

bind insn_fmt_agen insn_fmt_agen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
  .out_valid(out_valid), .out_fmt(out_fmt), .out_len(out_len),
  .out_unsup(out_unsup), .out_r2(out_r2), .out_ea(out_ea)
);

// File: tb/insn_fmt_agen_bench.sv
module insn_fmt_agen_bench;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [31:0] in_insn = '0;
  logic [3:0]  rd_base_sel, rd_idx_sel;
  logic [31:0] rd_base_data, rd_idx_data;
  logic        out_valid, out_unsup;
  logic [7:0]  out_opcode;
  logic [1:0]  out_fmt, out_len;
  logic [3:0]  out_r1, out_r2, out_base;
  logic [11:0] out_disp;
  logic [23:0] out_ea;
  logic [31:0] regs [16];
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  assign rd_base_data = regs[rd_base_sel];
  assign rd_idx_data  = regs[rd_idx_sel];

  insn_fmt_agen u_insn_fmt_agen (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model_ea(input logic [31:0] ins);
    logic [23:0] b, x;
    b = (ins[15:12] != 0) ? regs[ins[15:12]][23:0] : 24'd0;
    x = (ins[31:30] == 2'b01 && ins[19:16] != 0) ? regs[ins[19:16]][23:0] : 24'd0;
    if (ins[31:30] == 2'b00 || ins[31:30] == 2'b11) return 24'd0;
    return b + x + {12'd0, ins[11:0]};
  endfunction

  task automatic apply(input logic [31:0] ins);
    @(negedge clk);
    in_insn = ins; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 valid", out_valid, 0);
    chk("R1 unsup", out_unsup, 0);
    chk("R1 ea", out_ea, 0);
    chk("R1 opcode", out_opcode, 0);
  endtask

  task automatic t_rr;
    apply(32'h1A_37_5FFF);
    chk("R2 valid", out_valid, 1);
    chk("R3 fmt", out_fmt, 0);
    chk("R3 len", out_len, 1);
    chk("R6 opcode", out_opcode, 8'h1A);
    chk("R6 r1", out_r1, 3);
    chk("R6 r2", out_r2, 7);
    chk("R6 base", out_base, 0);
    chk("R6 disp", out_disp, 0);
    chk("R11 ea", out_ea, 0);
    @(negedge clk);
    chk("R2 drop", out_valid, 0);
  endtask

  task automatic t_rx;
    logic [31:0] ins = 32'h5A_37_4400;
    apply(ins);
    chk("R4 fmt", out_fmt, 1);
    chk("R4 len", out_len, 2);
    chk("R6 base", out_base, 4);
    chk("R6 disp", out_disp, 12'h400);
    chk("R7 ea", out_ea, model_ea(ins));
  endtask

  task automatic t_rs;
    logic [31:0] ins = 32'h98_47_2123;
    apply(ins);
    chk("R4 fmt", out_fmt, 2);
    chk("R4 len", out_len, 2);
    chk("R8 r3", out_r2, 7);
    chk("R8 ea", out_ea, {8'd0, regs[2][23:0]} + 32'h123);
  endtask

  task automatic t_zero_regs;
    apply(32'h98_47_0100);
    chk("R9 rs base0", out_ea, 24'h000100);
    apply(32'h5A_30_5010);
    chk("R10 rx idx0", out_ea, regs[5][23:0] + 24'h10);
    apply(32'h5A_35_0FFF);
    chk("R9 rx base0", out_ea, regs[5][23:0] + 24'hFFF);
  endtask

  task automatic t_wrap;
    apply(32'h5A_1E_F010);
    chk("R7 wrap", out_ea, 24'h000020);
  endtask

  task automatic t_unsup;
    apply(32'hD2_11_1111);
    chk("R5 unsup", out_unsup, 1);
    chk("R5 fmt", out_fmt, 3);
    chk("R5 len", out_len, 3);
    chk("R5 ea", out_ea, 0);
    apply(32'h5A_11_1000);
    chk("R5 cleared", out_unsup, 0);
  endtask

  task automatic t_ports;
    @(negedge clk);
    in_insn = 32'h00_0C_9000;
    #1;
    chk("R12 base sel", rd_base_sel, 9);
    chk("R12 idx sel", rd_idx_sel, 12);
  endtask

  task automatic t_idle;
    logic [23:0] held;
    apply(32'h5A_12_3456);
    held = out_ea;
    @(negedge clk);
    in_insn = 32'h5A_FF_F777;
    @(negedge clk);
    chk("R2 idle valid", out_valid, 0);
    chk("R2 idle hold", out_ea, held);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = {8'hC3, 24'(i * 24'h010203)};
    regs[0]  = 32'h7700_0ABC;
    regs[15] = 32'h12FF_FFF0;
    regs[14] = 32'hAB00_0020;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_rr;
    t_rx;
    t_rs;
    t_zero_regs;
    t_wrap;
    t_unsup;
    t_ports;
    t_idle;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule